// File: doc/BRIEF.md
# Descriptor-Driven Ping-Pong Read DMA

This block is a single-channel DMA engine. It reads data words from system memory and streams them to a peripheral through a 32-word (128-byte) internal buffer. The buffer is split into two 16-word halves. The memory side fills one half while the stream side empties the other. Software programs a descriptor-table base address, sets the enable bit, and can optionally turn on scatter-gather. A start pulse from the peripheral then sets the engine walking the table. The engine fetches every descriptor and its data with no further software help, and ends the transfer with a done flag and an interrupt pulse.

Each descriptor occupies two 32-bit words. The table is walked either sequentially or by following link entries. A link entry redirects the walk to another address, so the table can be scattered in memory. The engine offers one read at a time to a single request/grant memory master. When no transfer is running, software can read and write the whole buffer through the register port.

Top module: `pp_dma_engine`

## Requirements
- R1: After synchronous reset, `st_valid`, `mem_req` and `irq` are low, and the control, base and status registers read as zero.
- R2: Register map (byte offsets on `reg_addr`):
  - Offset 0x00 is control: bit 0 enable, bit 3 scatter-gather enable.
  - Offset 0x04 is the table base.
  - Offset 0x08 is status: bit 0 done, bit 1 error, bit 2 busy. Writing 1 to bit 0 or bit 1 clears that bit.
  - Writes to control and base are ignored while busy.
- R3: Offsets 0x80 + 4*i, for i in 0..31, address buffer word i. These words can be written and read back while idle. While busy, reads return zero and writes are ignored.
- R4: A `per_start` pulse while enabled and idle starts a walk at the base address with bits 1:0 cleared, so base bit 0 has no effect. A start pulse while disabled or busy is ignored.
- R5: Descriptor format:
  - Word 0 holds the data address. Its bits 1:0 are cleared for addressing, and bit 0 is the link flag.
  - Word 1 holds the byte count in bits 15:0, of which bits 1:0 are ignored, so the word count is bits 15:2. Bit 31 marks the end of the table.
- R6: In sequential walking, the next descriptor sits 8 bytes after the current one. A descriptor with a zero count moves no data. The walk ends after the descriptor whose end bit is 1.
- R7: With scatter-gather on, a word 0 with bit 0 = 1 is a link. The second word is not read, and the walk continues at word 0 with bits 1:0 cleared.
- R8: With scatter-gather off, exactly one descriptor is processed, and both its link flag and its end flag are ignored.
- R9: Data leaves on the stream port in table order. A half is handed to the stream side when it holds 16 words, or at the end of the final descriptor if it is partly filled. `st_valid` and `st_data` hold steady until `st_ready` is high.
- R10: `mem_req` and `mem_addr` hold steady until `mem_gnt`, and only one read is outstanding at a time. No data read is requested while the half being filled is still owned by the stream side.
- R11: After the last word of a transfer is taken, done is set, `irq` is high for exactly one cycle, and the enable bit clears itself.
- R12: A read response with `mem_err` high aborts the transfer. The error bit is set, `irq` pulses once, enable clears, and buffered data is discarded without being streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| per_start | input | 1 | Transfer start pulse from the peripheral |
| st_valid | output | 1 | Stream word available |
| st_data | output | 32 | Stream word |
| st_ready | input | 1 | Peripheral accepts the stream word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_err | input | 1 | Read response error, qualified by mem_rvalid |
| irq | output | 1 | One-cycle completion or abort pulse |

## Verification
The properties assume the memory side grants only while `mem_req` is high, and returns exactly one response, some cycles later, for each granted read. They also assume `mem_err` is meaningful only together with `mem_rvalid`. The bench's memory model grants at random and answers after a random latency of one to three cycles, so it never breaks these rules. Tables used in stimulus always end within a bounded walk. Byte counts are chosen so that partial halves, zero-count entries and stalled streams all occur.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_BASE = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;

    localparam int unsigned CTRL_EN_BIT = 0;
    localparam int unsigned CTRL_SG_BIT = 3;
    localparam int unsigned CNT_W       = 14;

    typedef enum logic [3:0] {
        W_IDLE,
        W_D0_REQ,
        W_D0_WAIT,
        W_D1_REQ,
        W_D1_WAIT,
        W_DAT_REQ,
        W_DAT_WAIT,
        W_FLUSH,
        W_DRAIN
    } walk_state_e;

    typedef struct packed {
        logic        link;
        logic [31:0] addr;
    } desc_head_t;

    typedef struct packed {
        logic             last;
        logic [CNT_W-1:0] words;
    } desc_tail_t;

    function automatic logic [31:0] align_word(input logic [31:0] a);
        return {a[31:2], 2'b00};
    endfunction

    function automatic desc_head_t decode_head(input logic [31:0] w, input logic sg);
        desc_head_t h;
        h.link = sg & w[0];
        h.addr = align_word(w);
        return h;
    endfunction

    function automatic desc_tail_t decode_tail(input logic [31:0] w, input logic sg);
        desc_tail_t t;
        t.words = w[CNT_W+1:2];
        t.last  = w[31] | ~sg;
        return t;
    endfunction

endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
    import pp_dma_pkg::*;
#(
    parameter int unsigned BUF_WORDS = 32,
    localparam int unsigned IDX_W    = $clog2(BUF_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic             done_p,
    input  logic             err_p,
    input  logic [31:0]      buf_rdata,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_idx,
    output logic [31:0]      buf_wdata,
    output logic             en,
    output logic             sg,
    output logic [31:0]      base,
    output logic             irq
);

    logic done_q, err_q, en_q, sg_q, irq_q;
    logic [31:0] base_q;
    logic in_window;

    assign in_window = reg_addr[7];
    assign buf_idx   = reg_addr[IDX_W+1:2];
    assign buf_wdata = reg_wdata;
    assign buf_we    = reg_we && in_window && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            sg_q   <= 1'b0;
            base_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= done_p | err_p;
            if (reg_we && !busy && reg_addr == OFS_CTRL) begin
                en_q <= reg_wdata[CTRL_EN_BIT];
                sg_q <= reg_wdata[CTRL_SG_BIT];
            end
            if (reg_we && !busy && reg_addr == OFS_BASE) begin
                base_q <= reg_wdata;
            end
            if (reg_we && reg_addr == OFS_STAT) begin
                if (reg_wdata[0]) done_q <= 1'b0;
                if (reg_wdata[1]) err_q  <= 1'b0;
            end
            if (done_p) done_q <= 1'b1;
            if (err_p)  err_q  <= 1'b1;
            if (done_p || err_p) en_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_window) begin
            reg_rdata = busy ? 32'd0 : buf_rdata;
        end else begin
            case (reg_addr)
                OFS_CTRL: begin
                    reg_rdata[CTRL_EN_BIT] = en_q;
                    reg_rdata[CTRL_SG_BIT] = sg_q;
                end
                OFS_BASE: reg_rdata = base_q;
                OFS_STAT: reg_rdata = {29'd0, busy, err_q, done_q};
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign en   = en_q;
    assign sg   = sg_q;
    assign base = base_q;
    assign irq  = irq_q;

endmodule

// File: rtl/pp_dma_walker.sv
module pp_dma_walker
    import pp_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        en,
    input  logic        sg,
    input  logic [31:0] base,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err,
    input  logic        fill_ok,
    input  logic        drained,
    output logic        wr_en,
    output logic [31:0] wr_data,
    output logic        flush,
    output logic        busy,
    output logic        done_p,
    output logic        err_p
);

    walk_state_e state_q, state_d;
    logic [31:0] dptr_q, dptr_d, xptr_q, xptr_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic final_q, final_d;
    desc_head_t head;
    desc_tail_t tail;
    logic waiting;

    assign head    = decode_head(mem_rdata, sg);
    assign tail    = decode_tail(mem_rdata, sg);
    assign waiting = (state_q == W_D0_WAIT) || (state_q == W_D1_WAIT) || (state_q == W_DAT_WAIT);
    assign err_p   = waiting && mem_rvalid && mem_err;
    assign wr_en   = (state_q == W_DAT_WAIT) && mem_rvalid && !mem_err;
    assign wr_data = mem_rdata;
    assign flush   = (state_q == W_FLUSH);
    assign busy    = (state_q != W_IDLE);
    assign done_p  = (state_q == W_DRAIN) && drained;

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = dptr_q;
        case (state_q)
            W_D0_REQ:  mem_req = 1'b1;
            W_D1_REQ: begin
                mem_req  = 1'b1;
                mem_addr = dptr_q + 32'd4;
            end
            W_DAT_REQ: begin
                mem_req  = fill_ok;
                mem_addr = xptr_q;
            end
            default: mem_req = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        dptr_d  = dptr_q;
        xptr_d  = xptr_q;
        left_d  = left_q;
        final_d = final_q;
        case (state_q)
            W_IDLE: begin
                if (start && en) begin
                    dptr_d  = align_word(base);
                    state_d = W_D0_REQ;
                end
            end
            W_D0_REQ:  if (mem_gnt) state_d = W_D0_WAIT;
            W_D0_WAIT: begin
                if (mem_rvalid) begin
                    if (mem_err) begin
                        state_d = W_IDLE;
                    end else if (head.link) begin
                        dptr_d  = head.addr;
                        state_d = W_D0_REQ;
                    end else begin
                        xptr_d  = head.addr;
                        state_d = W_D1_REQ;
                    end
                end
            end
            W_D1_REQ:  if (mem_gnt) state_d = W_D1_WAIT;
            W_D1_WAIT: begin
                if (mem_rvalid) begin
                    if (mem_err) begin
                        state_d = W_IDLE;
                    end else begin
                        left_d  = tail.words;
                        final_d = tail.last;
                        dptr_d  = dptr_q + 32'd8;
                        if (tail.words == '0) begin
                            state_d = tail.last ? W_FLUSH : W_D0_REQ;
                        end else begin
                            state_d = W_DAT_REQ;
                        end
                    end
                end
            end
            W_DAT_REQ: if (mem_req && mem_gnt) state_d = W_DAT_WAIT;
            W_DAT_WAIT: begin
                if (mem_rvalid) begin
                    if (mem_err) begin
                        state_d = W_IDLE;
                    end else begin
                        xptr_d = xptr_q + 32'd4;
                        left_d = left_q - CNT_W'(1);
                        if (left_q == CNT_W'(1)) begin
                            state_d = final_q ? W_FLUSH : W_D0_REQ;
                        end else begin
                            state_d = W_DAT_REQ;
                        end
                    end
                end
            end
            W_FLUSH: state_d = W_DRAIN;
            W_DRAIN: if (drained) state_d = W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            dptr_q  <= '0;
            xptr_q  <= '0;
            left_q  <= '0;
            final_q <= 1'b0;
        end else begin
            state_q <= state_d;
            dptr_q  <= dptr_d;
            xptr_q  <= xptr_d;
            left_q  <= left_d;
            final_q <= final_d;
        end
    end

endmodule

// File: rtl/pp_dma_pingpong.sv
module pp_dma_pingpong #(
    parameter int unsigned HALF_WORDS = 16,
    parameter int unsigned DW         = 32,
    localparam int unsigned PTR_W     = $clog2(HALF_WORDS),
    localparam int unsigned LEN_W     = PTR_W + 1,
    localparam int unsigned BUF_WORDS = 2 * HALF_WORDS,
    localparam int unsigned IDX_W     = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             flush,
    output logic             fill_ok,
    output logic             drained,
    output logic             st_valid,
    output logic [DW-1:0]    st_data,
    input  logic             st_ready,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [DW-1:0]    sw_wdata,
    output logic [DW-1:0]    sw_rdata
);

    logic [DW-1:0] store_q [BUF_WORDS];
    logic             fh_q, dh_q;
    logic [PTR_W-1:0] fp_q, dp_q;
    logic [1:0]       full_w;
    logic [LEN_W-1:0] len_w [2];
    logic             commit, release_h, pop;
    logic [LEN_W-1:0] commit_len;

    assign commit     = (wr_en && fp_q == PTR_W'(HALF_WORDS - 1)) || (flush && fp_q != '0);
    assign commit_len = wr_en ? LEN_W'(HALF_WORDS) : {1'b0, fp_q};
    assign fill_ok    = !full_w[fh_q];
    assign drained    = (full_w == 2'b00);
    assign st_valid   = full_w[dh_q];
    assign st_data    = store_q[{dh_q, dp_q}];
    assign pop        = st_valid && st_ready;
    assign release_h  = pop && ((LEN_W'(dp_q) + LEN_W'(1)) == len_w[dh_q]);
    assign sw_rdata   = store_q[sw_idx];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic             full_r;
        logic [LEN_W-1:0] len_r;
        always_ff @(posedge clk) begin
            if (rst || abort) begin
                full_r <= 1'b0;
                len_r  <= '0;
            end else if (commit && fh_q == 1'(h)) begin
                full_r <= 1'b1;
                len_r  <= commit_len;
            end else if (release_h && dh_q == 1'(h)) begin
                full_r <= 1'b0;
            end
        end
        assign full_w[h] = full_r;
        assign len_w[h]  = len_r;
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            fh_q <= 1'b0;
            fp_q <= '0;
        end else if (wr_en) begin
            fp_q <= (fp_q == PTR_W'(HALF_WORDS - 1)) ? '0 : fp_q + PTR_W'(1);
            if (commit) fh_q <= ~fh_q;
        end else if (flush) begin
            fp_q <= '0;
            if (commit) fh_q <= ~fh_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            dh_q <= 1'b0;
            dp_q <= '0;
        end else if (release_h) begin
            dh_q <= ~dh_q;
            dp_q <= '0;
        end else if (pop) begin
            dp_q <= dp_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[{fh_q, fp_q}] <= wr_data;
        end else if (sw_we) begin
            store_q[sw_idx] <= sw_wdata;
        end
    end

endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
    import pp_dma_pkg::*;
#(
    parameter int unsigned HALF_WORDS = 16,
    localparam int unsigned BUF_WORDS = 2 * HALF_WORDS,
    localparam int unsigned IDX_W     = $clog2(BUF_WORDS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        per_start,
    output logic        st_valid,
    output logic [31:0] st_data,
    input  logic        st_ready,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err,
    output logic        irq
);

    logic busy, done_p, err_p, ctrl_en, ctrl_sg;
    logic [31:0] tbl_base;
    logic fill_ok, drained, wr_en, flush;
    logic [31:0] wr_data;
    logic buf_we;
    logic [IDX_W-1:0] buf_idx;
    logic [31:0] buf_wdata, buf_rdata;

    pp_dma_regs #(.BUF_WORDS(BUF_WORDS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy     (busy),
        .done_p   (done_p),
        .err_p    (err_p),
        .buf_rdata(buf_rdata),
        .buf_we   (buf_we),
        .buf_idx  (buf_idx),
        .buf_wdata(buf_wdata),
        .en       (ctrl_en),
        .sg       (ctrl_sg),
        .base     (tbl_base),
        .irq      (irq)
    );

    pp_dma_walker u_walker (
        .clk       (clk),
        .rst       (rst),
        .start     (per_start),
        .en        (ctrl_en),
        .sg        (ctrl_sg),
        .base      (tbl_base),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_gnt   (mem_gnt),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .mem_err   (mem_err),
        .fill_ok   (fill_ok),
        .drained   (drained),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .flush     (flush),
        .busy      (busy),
        .done_p    (done_p),
        .err_p     (err_p)
    );

    pp_dma_pingpong #(.HALF_WORDS(HALF_WORDS), .DW(32)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .abort   (err_p),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .flush   (flush),
        .fill_ok (fill_ok),
        .drained (drained),
        .st_valid(st_valid),
        .st_data (st_data),
        .st_ready(st_ready),
        .sw_we   (buf_we),
        .sw_idx  (buf_idx),
        .sw_wdata(buf_wdata),
        .sw_rdata(buf_rdata)
    );

endmodule

// File: rtl/pp_dma_sva.sv
module pp_dma_sva (
    input logic        clk,
    input logic        rst,
    input logic        st_valid,
    input logic        st_ready,
    input logic [31:0] st_data,
    input logic        mem_req,
    input logic        mem_gnt,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        mem_err,
    input logic        irq,
    input logic        busy,
    input logic        ctrl_en
);

    // R9: a waiting stream word stays put unless an abort drops it
    a_r9_stream_hold: assert property (@(posedge clk) disable iff (rst)
        st_valid && !st_ready && !(mem_rvalid && mem_err) |=> st_valid && $stable(st_data));

    // R10: request and address hold until granted
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

    // R4: no memory traffic while idle
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R11: interrupt lasts one cycle
    a_r11_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R11: end of a transfer leaves the engine disabled
    a_r11_en_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !ctrl_en);

    // R12: an error response aborts at once
    a_r12_abort: assert property (@(posedge clk) disable iff (rst)
        busy && mem_rvalid && mem_err |=> !busy && !st_valid && !ctrl_en);

endmodule

bind pp_dma_engine pp_dma_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_data   (st_data),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .mem_err   (mem_err),
    .irq       (irq),
    .busy      (busy),
    .ctrl_en   (ctrl_en)
);

// File: tb/pp_dma_engine_bench.sv
module pp_dma_engine_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        per_start = 1'b0;
    logic        st_valid;
    logic [31:0] st_data;
    logic        st_ready = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        irq;

    pp_dma_engine u_pp_dma_engine (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_start(per_start),
        .st_valid(st_valid), .st_data(st_data), .st_ready(st_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .irq(irq)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    int grant_cnt = 0;
    int ready_mode = 0;
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    logic [31:0] bmem [logic [31:0]];
    logic [31:0] expq [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : 32'd0;
    endfunction

    // Memory model: random grant, one outstanding read, latency 1..3
    logic        pend = 1'b0;
    int          lat = 0;
    logic [31:0] paddr = '0;
    always @(negedge clk) begin
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b0;
        mem_err    = 1'b0;
        mem_rdata  = '0;
        if (pend) begin
            if (lat <= 1) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd(paddr);
                mem_err    = (paddr == err_addr);
                pend       = 1'b0;
            end else begin
                lat--;
            end
        end else if (!rst && mem_req && ($urandom % 3 != 0)) begin
            mem_gnt = 1'b1;
            pend    = 1'b1;
            paddr   = mem_addr;
            lat     = 1 + ($urandom % 3);
            grant_cnt++;
        end
    end

    // Stream sink and reference comparison
    always @(negedge clk) begin
        logic r;
        logic [31:0] e;
        case (ready_mode)
            0:       r = 1'b1;
            1:       r = 1'($urandom % 2);
            default: r = 1'b0;
        endcase
        st_ready = r;
        if (!rst && st_valid && r) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R9/R12 unexpected stream word", st_data, 32'd0);
            end else begin
                e = expq.pop_front();
                chk(st_data == e, "R9 stream word order", st_data, e);
            end
        end
        if (!rst && irq) irq_cnt++;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        per_start = 1'b1;
        @(negedge clk);
        per_start = 1'b0;
    endtask

    task automatic fill_data(input logic [31:0] a, input int n);
        for (int i = 0; i < n; i++) bmem[a + 32'(4 * i)] = 32'hA500_0000 ^ (a + 32'(4 * i)) ^ 32'(i * 7);
    endtask

    // Behavioural table walk producing the expected stream
    task automatic build_expected(input logic [31:0] base, input bit sg);
        logic [31:0] p, w0, w1;
        int n;
        p = {base[31:2], 2'b00};
        for (int it = 0; it < 64; it++) begin
            w0 = rd(p);
            if (sg && w0[0]) begin
                p = {w0[31:2], 2'b00};
                continue;
            end
            w1 = rd(p + 32'd4);
            n  = int'(w1[15:2]);
            for (int i = 0; i < n; i++) expq.push_back(rd({w0[31:2], 2'b00} + 32'(4 * i)));
            p = p + 32'd8;
            if (w1[31] || !sg) break;
        end
    endtask

    task automatic wait_irq(input string req);
        int c0 = irq_cnt;
        int k = 0;
        while (irq_cnt == c0 && k < 20000) begin
            @(negedge clk);
            k++;
        end
        repeat (5) @(negedge clk);
        chk(irq_cnt - c0 == 1, req, 32'(irq_cnt - c0), 32'd1);
    endtask

    task automatic run_and_check(input logic [31:0] base, input bit sg, input string tag);
        logic [31:0] d;
        reg_write(8'h04, base);
        reg_write(8'h00, sg ? 32'h9 : 32'h1);
        pulse_start();
        wait_irq({tag, " R11 irq once"});
        chk(expq.size() == 0, {tag, " R9 all words delivered"}, 32'(expq.size()), 32'd0);
        reg_read(8'h08, d);
        chk(d == 32'h1, {tag, " R11 status done"}, d, 32'h1);
        reg_read(8'h00, d);
        chk(d[0] == 1'b0, {tag, " R11 enable cleared"}, d, {d[31:1], 1'b0});
        reg_write(8'h08, 32'h3);
        reg_read(8'h08, d);
        chk(d == 32'h0, {tag, " R2 status cleared"}, d, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(!st_valid && !mem_req && !irq, "R1 outputs idle", {29'd0, st_valid, mem_req, irq}, 32'd0);
        reg_read(8'h00, d); chk(d == 0, "R1 control zero", d, 0);
        reg_read(8'h04, d); chk(d == 0, "R1 base zero", d, 0);
        reg_read(8'h08, d); chk(d == 0, "R1 status zero", d, 0);

        // R3: direct buffer access while idle
        reg_write(8'h80, 32'h1111_0000);
        reg_write(8'h9C, 32'h2222_0007);
        reg_write(8'hFC, 32'h3333_001F);
        reg_read(8'h80, d); chk(d == 32'h1111_0000, "R3 buffer word 0", d, 32'h1111_0000);
        reg_read(8'h9C, d); chk(d == 32'h2222_0007, "R3 buffer word 7", d, 32'h2222_0007);
        reg_read(8'hFC, d); chk(d == 32'h3333_001F, "R3 buffer word 31", d, 32'h3333_001F);

        // R4: start while disabled is ignored
        reg_write(8'h04, 32'h0000_8000);
        reg_write(8'h00, 32'h0);
        grant_cnt = 0;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(grant_cnt == 0, "R4 no reads while disabled", 32'(grant_cnt), 0);
        reg_read(8'h08, d); chk(d == 0, "R4 not busy after ignored start", d, 0);

        // R8 + R9: scatter-gather off, one descriptor, flags ignored, 20 words
        bmem[32'h8000] = 32'h0000_9001;
        bmem[32'h8004] = 32'h0000_0050;
        bmem[32'h8008] = 32'h0000_9800;
        bmem[32'h800C] = 32'h8000_0010;
        fill_data(32'h9000, 20);
        fill_data(32'h9800, 4);
        ready_mode = 0;
        build_expected(32'h8000, 1'b0);
        chk(expq.size() == 20, "R8 single descriptor length", 32'(expq.size()), 20);
        run_and_check(32'h8000, 1'b0, "R8");

        // R5 + R6 + R4: sequential table, base bit 0 set, zero-count entry, ignored count bits
        bmem[32'h4000] = 32'h0000_7000; bmem[32'h4004] = 32'h0000_0028;
        bmem[32'h4008] = 32'h0000_7100; bmem[32'h400C] = 32'h0000_0000;
        bmem[32'h4010] = 32'h0000_7202; bmem[32'h4014] = 32'h8000_001F;
        fill_data(32'h7000, 10);
        fill_data(32'h7200, 7);
        ready_mode = 1;
        build_expected(32'h4001, 1'b1);
        chk(expq.size() == 17, "R6 sequential length", 32'(expq.size()), 17);
        run_and_check(32'h4001, 1'b1, "R6");

        // R7: linked table
        bmem[32'h1000] = 32'h0000_2001;
        bmem[32'h2000] = 32'h0000_5000; bmem[32'h2004] = 32'h0000_0014;
        bmem[32'h2008] = 32'h0000_3001;
        bmem[32'h3000] = 32'h0000_6000; bmem[32'h3004] = 32'h8000_0048;
        fill_data(32'h5000, 5);
        fill_data(32'h6000, 18);
        build_expected(32'h1000, 1'b1);
        chk(expq.size() == 23, "R7 linked length", 32'(expq.size()), 23);
        run_and_check(32'h1000, 1'b1, "R7");

        // R10 + R2 + R3 + R4: stalled stream, 60 words
        bmem[32'hA000] = 32'h0000_B000; bmem[32'hA004] = 32'h8000_00F0;
        fill_data(32'hB000, 60);
        build_expected(32'hA000, 1'b1);
        ready_mode = 2;
        reg_write(8'h04, 32'h0000_A000);
        reg_write(8'h00, 32'h9);
        grant_cnt = 0;
        pulse_start();
        repeat (300) @(negedge clk);
        chk(grant_cnt == 34, "R10 reads stop with both halves full", 32'(grant_cnt), 34);
        reg_read(8'h80, d); chk(d == 0, "R3 buffer reads zero while busy", d, 0);
        reg_write(8'h04, 32'h0000_1234);
        pulse_start();
        reg_read(8'h08, d); chk(d == 32'h4, "R2 busy flag", d, 32'h4);
        ready_mode = 1;
        wait_irq("R11 irq once after stall");
        chk(expq.size() == 0, "R9 stalled words delivered", 32'(expq.size()), 0);
        reg_read(8'h04, d); chk(d == 32'h0000_A000, "R2 base write while busy ignored", d, 32'h0000_A000);
        reg_write(8'h08, 32'h3);

        // R12: error on first descriptor word
        err_addr = 32'hC000;
        bmem[32'hC000] = 32'h0000_D000;
        reg_write(8'h04, 32'h0000_C000);
        reg_write(8'h00, 32'h9);
        pulse_start();
        wait_irq("R12 irq once on descriptor error");
        reg_read(8'h08, d); chk(d == 32'h2, "R12 error status", d, 32'h2);
        reg_read(8'h00, d); chk(d[0] == 1'b0, "R12 enable cleared", d, {d[31:1], 1'b0});
        reg_write(8'h08, 32'h3);

        // R12: error during data, partial half discarded
        err_addr = 32'hD00C;
        bmem[32'hC100] = 32'h0000_D000; bmem[32'hC104] = 32'h8000_0050;
        fill_data(32'hD000, 20);
        reg_write(8'h04, 32'h0000_C100);
        reg_write(8'h00, 32'h9);
        pulse_start();
        wait_irq("R12 irq once on data error");
        repeat (20) @(negedge clk);
        reg_read(8'h08, d); chk(d == 32'h2, "R12 error status on data", d, 32'h2);
        chk(!st_valid, "R12 nothing streamed after abort", {31'd0, st_valid}, 0);
        reg_write(8'h08, 32'h3);
        err_addr = 32'hFFFF_FFF0;

        // Recovery after abort: full transfer again
        build_expected(32'h8000, 1'b0);
        run_and_check(32'h8000, 1'b0, "R12 recovery");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule